// File: doc/BRIEF.md
# Serial Channel FIFO Control Registers

This block is the per-channel register slice of a four-channel serial interface. Each channel has a control/status word. Its upper byte shows the current receive and transmit FIFO flags, inverted so that a 0 means the condition holds. Its lower byte accepts one-shot commands: clear the receive FIFO, clear the transmit FIFO, or reset the serial controller. Channels are grouped in pairs, and each pair shares one serial controller. A controller reset from either channel of a pair therefore hits both channels.

After a controller reset, the block guards that controller's 256-byte window. The only access allowed through is a write of zero to the window's base. Every other access is blocked and flagged as an error. The required write is forwarded and reopens the window.

Each channel also holds a sync byte. When the receive FIFO of that channel is loaded with a byte equal to it, and the channel's enable is set, a sticky interrupt request is raised. It stays set until the per-channel clear input is pulsed.

Top module: `sio_chan_regs`

## Requirements
- R1: The control/status word of channel c (c = 0..3) is at offset 0x1C + 0x10·c. Bits 15:12 read `rx_flags_ni[4c+3:4c]` (full, almost full, almost empty, empty from bit 15 down). Bits 11:8 read `tx_flags_ni[4c+3:4c]` in the same order. Both are unmodified, so a 0 means the condition holds.
- R2: Reading a control/status word returns 0 in bits 31:16 and 7:0. Reading a sync word returns 0 in bits 31:8. Writes to those reserved bits have no effect on any output.
- R3: Writing a control/status word with bit 0 set drives `tx_fifo_clr_o[c]` high for exactly the one cycle after the write edge, and for that channel only.
- R4: Writing a control/status word with bit 1 set drives `rx_fifo_clr_o[c]` high for exactly the one cycle after the write edge, and for that channel only.
- R5: Writing bit 7 set to the word of channel 2p or 2p+1 drives `ctl_rst_o[p]` high for one cycle after the write edge. The other pair is not touched. Several command bits in one write all take effect together.
- R6: After a reset of controller p, `ctl_lock_o[p]` is 1 and accesses to its window (0x100 + 0x200·p up to 0xFF above) do not raise `ctl_sel_o[p]`. The exception is a write of data 0 to the window base: it raises `ctl_sel_o[p]` and clears the lock. An unlocked window forwards every access.
- R7: A blocked access sets `ctl_err_o[p]`. The flag stays set until the next reset of controller p clears it.
- R8: The sync word of channel c is at 0x50 + 4·c. It stores bits 7:0 of a write and reads them back.
- R9: A receive-FIFO load (`rxf_wr_i[c]`) whose byte equals the channel's sync byte while `sync_irq_en_i[c]` is 1 sets `sync_irq_o[c]` at that edge. A mismatched byte or a disabled channel leaves it unchanged.
- R10: `sync_irq_o[c]` stays set until `sync_irq_clr_i[c]` is 1 at an edge. A match at the same edge as the clear keeps it set.
- R11: After reset, all pulses, IRQs, locks and error flags are 0, and all sync bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational from address) |
| rx_flags_ni | input | 16 | Receive FIFO flags, 4 per channel, active low |
| tx_flags_ni | input | 16 | Transmit FIFO flags, 4 per channel, active low |
| rxf_wr_i | input | 4 | Receive FIFO load strobe per channel |
| rxf_wdata_i | input | 32 | Byte loaded into each receive FIFO |
| sync_irq_en_i | input | 4 | Sync-match interrupt enable per channel |
| sync_irq_clr_i | input | 4 | Sync-match interrupt clear per channel |
| sync_irq_o | output | 4 | Sticky sync-match interrupt request |
| rx_fifo_clr_o | output | 4 | Receive FIFO clear pulse |
| tx_fifo_clr_o | output | 4 | Transmit FIFO clear pulse |
| ctl_rst_o | output | 2 | Serial controller reset pulse per pair |
| ctl_sel_o | output | 2 | Access forwarded to controller window |
| ctl_lock_o | output | 2 | Controller awaiting its initial zero write |
| ctl_err_o | output | 2 | Blocked access seen since last controller reset |

## Verification
The bench targets the pair sharing of the controller reset. A design that decoded only one channel of a pair, or reset the wrong controller, produces a pulse that the scoreboard does not expect.

It probes the locked window with a read, a non-zero write to the base and a zero write elsewhere. A guard that let any of these through would raise the select or leave the error flag clear.

It drives a sync match on the same edge as the clear, and a match with the enable low. A clear-wins priority or an ignored enable shows up as a wrong IRQ level.

Reserved-bit writes carrying all ones check that no stray pulse leaks out of bits 6:2 or 31:16.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
  localparam int unsigned CSR_BASE     = 'h01C;
  localparam int unsigned CSR_STEP     = 'h010;
  localparam int unsigned SYNC_BASE    = 'h050;
  localparam int unsigned SYNC_STEP    = 'h004;
  localparam int unsigned WIN_BASE     = 'h100;
  localparam int unsigned WIN_STEP     = 'h200;
  localparam int unsigned WIN_SPAN     = 'h100;
  localparam int unsigned BIT_CTL_RST  = 7;
  localparam int unsigned BIT_RX_CLR   = 1;
  localparam int unsigned BIT_TX_CLR   = 0;
  localparam int unsigned FLAG_W       = 4;
  localparam int unsigned BYTE_W       = 8;
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
  import sio_regs_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned N_PAIR = N_CH / 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   csr_hit_o,
  output logic [N_CH-1:0]   sync_hit_o,
  output logic [N_PAIR-1:0] win_hit_o,
  output logic [N_PAIR-1:0] win_base_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_BASE + g * CSR_STEP);
    localparam logic [ADDR_W-1:0] SYNC_A = ADDR_W'(SYNC_BASE + g * SYNC_STEP);
    assign csr_hit_o[g]  = (addr_i == CSR_A);
    assign sync_hit_o[g] = (addr_i == SYNC_A);
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    localparam int unsigned LO = WIN_BASE + p * WIN_STEP;
    localparam int unsigned HI = LO + WIN_SPAN;
    assign win_hit_o[p]  = (32'(addr_i) >= LO) && (32'(addr_i) < HI);
    assign win_base_o[p] = (32'(addr_i) == LO);
  end
endmodule

// File: rtl/sio_sync_det.sv
module sio_sync_det
  import sio_regs_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        cfg_we_i,
  input  logic [BYTE_W-1:0]      cfg_wdata_i,
  input  logic [N_CH-1:0]        rxf_wr_i,
  input  logic [N_CH*BYTE_W-1:0] rxf_wdata_i,
  input  logic [N_CH-1:0]        en_i,
  input  logic [N_CH-1:0]        clr_i,
  output logic [N_CH*BYTE_W-1:0] sync_byte_o,
  output logic [N_CH-1:0]        irq_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [BYTE_W-1:0] pat_q;
    logic              irq_q;
    logic              hit;

    assign hit = rxf_wr_i[g] && en_i[g] &&
                 (rxf_wdata_i[g*BYTE_W +: BYTE_W] == pat_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pat_q <= '0;
        irq_q <= 1'b0;
      end else begin
        if (cfg_we_i[g]) pat_q <= cfg_wdata_i;
        // set wins over clear so a match is never lost
        if (hit)           irq_q <= 1'b1;
        else if (clr_i[g]) irq_q <= 1'b0;
      end
    end

    assign sync_byte_o[g*BYTE_W +: BYTE_W] = pat_q;
    assign irq_o[g] = irq_q;
  end
endmodule

// File: rtl/sio_ctl_guard.sv
module sio_ctl_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_req_i,
  input  logic acc_i,
  input  logic init_ok_i,
  output logic ctl_rst_o,
  output logic sel_o,
  output logic lock_o,
  output logic err_o
);
  logic rst_q, lock_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rst_q <= rst_req_i;
      if (rst_req_i) begin
        lock_q <= 1'b1;
        err_q  <= 1'b0;
      end else if (lock_q && acc_i) begin
        if (init_ok_i) lock_q <= 1'b0;
        else           err_q  <= 1'b1;
      end
    end
  end

  assign sel_o     = acc_i && (!lock_q || init_ok_i);
  assign ctl_rst_o = rst_q;
  assign lock_o    = lock_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
  import sio_regs_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_PAIR = N_CH / 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  input  logic [N_CH*FLAG_W-1:0] rx_flags_ni,
  input  logic [N_CH*FLAG_W-1:0] tx_flags_ni,
  input  logic [N_CH-1:0]        rxf_wr_i,
  input  logic [N_CH*BYTE_W-1:0] rxf_wdata_i,
  input  logic [N_CH-1:0]        sync_irq_en_i,
  input  logic [N_CH-1:0]        sync_irq_clr_i,
  output logic [N_CH-1:0]        sync_irq_o,
  output logic [N_CH-1:0]        rx_fifo_clr_o,
  output logic [N_CH-1:0]        tx_fifo_clr_o,
  output logic [N_PAIR-1:0]      ctl_rst_o,
  output logic [N_PAIR-1:0]      ctl_sel_o,
  output logic [N_PAIR-1:0]      ctl_lock_o,
  output logic [N_PAIR-1:0]      ctl_err_o
);
  logic [N_CH-1:0]        csr_hit, sync_hit;
  logic [N_PAIR-1:0]      win_hit, win_base;
  logic [N_CH*BYTE_W-1:0] sync_bytes;
  logic [N_CH-1:0]        rx_clr_q, tx_clr_q;
  logic                   zero_wr;

  sio_addr_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i    (reg_addr_i),
    .csr_hit_o (csr_hit),
    .sync_hit_o(sync_hit),
    .win_hit_o (win_hit),
    .win_base_o(win_base)
  );

  sio_sync_det #(.N_CH(N_CH)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (sync_hit & {N_CH{reg_wr_i}}),
    .cfg_wdata_i(reg_wdata_i[BYTE_W-1:0]),
    .rxf_wr_i   (rxf_wr_i),
    .rxf_wdata_i(rxf_wdata_i),
    .en_i       (sync_irq_en_i),
    .clr_i      (sync_irq_clr_i),
    .sync_byte_o(sync_bytes),
    .irq_o      (sync_irq_o)
  );

  // FIFO clear pulses: one cycle, registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_clr_q <= '0;
      tx_clr_q <= '0;
    end else begin
      rx_clr_q <= csr_hit & {N_CH{reg_wr_i && reg_wdata_i[BIT_RX_CLR]}};
      tx_clr_q <= csr_hit & {N_CH{reg_wr_i && reg_wdata_i[BIT_TX_CLR]}};
    end
  end
  assign rx_fifo_clr_o = rx_clr_q;
  assign tx_fifo_clr_o = tx_clr_q;

  assign zero_wr = reg_wr_i && (reg_wdata_i == '0);

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic rst_req;
    assign rst_req = reg_wr_i && reg_wdata_i[BIT_CTL_RST] &&
                     (csr_hit[2*p] || csr_hit[2*p+1]);
    sio_ctl_guard u_guard (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rst_req_i(rst_req),
      .acc_i    ((reg_wr_i || reg_rd_i) && win_hit[p]),
      .init_ok_i(zero_wr && win_base[p]),
      .ctl_rst_o(ctl_rst_o[p]),
      .sel_o    (ctl_sel_o[p]),
      .lock_o   (ctl_lock_o[p]),
      .err_o    (ctl_err_o[p])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (csr_hit[c])
        reg_rdata_o[15:8] = {rx_flags_ni[c*FLAG_W +: FLAG_W],
                             tx_flags_ni[c*FLAG_W +: FLAG_W]};
      if (sync_hit[c])
        reg_rdata_o[BYTE_W-1:0] = sync_bytes[c*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sio_chan_regs_chk.sv
module sio_chan_regs_chk
  import sio_regs_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_PAIR = N_CH / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [N_CH-1:0]   sync_irq_clr_i,
  input logic [N_CH-1:0]   sync_irq_o,
  input logic [N_CH-1:0]   rx_fifo_clr_o,
  input logic [N_CH-1:0]   tx_fifo_clr_o,
  input logic [N_PAIR-1:0] ctl_rst_o,
  input logic [N_PAIR-1:0] ctl_sel_o,
  input logic [N_PAIR-1:0] ctl_lock_o,
  input logic [N_PAIR-1:0] ctl_err_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CSR_BASE + c * CSR_STEP);

    AST_TX_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_fifo_clr_o[c] |-> $past(reg_wr_i && reg_addr_i == CA && reg_wdata_i[BIT_TX_CLR])); // R3

    AST_RX_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_fifo_clr_o[c] |-> $past(reg_wr_i && reg_addr_i == CA && reg_wdata_i[BIT_RX_CLR])); // R4

    AST_CSR_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == CA) |-> (reg_rdata_o[31:16] == '0 && reg_rdata_o[7:0] == '0)); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_irq_o[c] && !sync_irq_clr_i[c]) |=> sync_irq_o[c]); // R10
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] CA0 = ADDR_W'(CSR_BASE + (2*p) * CSR_STEP);
    localparam logic [ADDR_W-1:0] CA1 = ADDR_W'(CSR_BASE + (2*p+1) * CSR_STEP);
    localparam logic [ADDR_W-1:0] WB  = ADDR_W'(WIN_BASE + p * WIN_STEP);
    logic in_win;
    assign in_win = (reg_addr_i >= WB) && (32'(reg_addr_i) < 32'(WB) + WIN_SPAN);

    AST_CTL_RST_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_rst_o[p] |-> $past(reg_wr_i && reg_wdata_i[BIT_CTL_RST] &&
                             (reg_addr_i == CA0 || reg_addr_i == CA1))); // R5

    AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_lock_o[p] && (reg_wr_i || reg_rd_i) && in_win &&
       !(reg_wr_i && reg_addr_i == WB && reg_wdata_i == '0)) |-> !ctl_sel_o[p]); // R6

    AST_LOCK_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_rst_o[p] |-> ctl_lock_o[p]); // R6

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ctl_err_o[p]) && !ctl_rst_o[p]) |-> ctl_err_o[p]); // R7
  end
endmodule

bind sio_chan_regs sio_chan_regs_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sio_chan_regs.sv
`timescale 1ns/1ps
module tb_sio_chan_regs;
  localparam int N_CH = 4;
  localparam int N_PAIR = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] rx_flags_ni = '1, tx_flags_ni = '1;
  logic [3:0]  rxf_wr_i = '0;
  logic [31:0] rxf_wdata_i = '0;
  logic [3:0]  sync_irq_en_i = '0, sync_irq_clr_i = '0;
  logic [3:0]  sync_irq_o, rx_fifo_clr_o, tx_fifo_clr_o;
  logic [1:0]  ctl_rst_o, ctl_sel_o, ctl_lock_o, ctl_err_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  sio_chan_regs dut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pulse vector {ctl_rst[1:0], rx[3:0], tx[3:0]}
  always @(negedge clk_i) begin
    if (rst_ni && ({ctl_rst_o, rx_fifo_clr_o, tx_fifo_clr_o} != '0)) begin
      if (exp_q.size() == 0)
        chk("R3/R4/R5 unexpected pulse", {22'b0, ctl_rst_o, rx_fifo_clr_o, tx_fifo_clr_o}, 32'h0);
      else
        chk(tag_q.pop_front(), {22'b0, ctl_rst_o, rx_fifo_clr_o, tx_fifo_clr_o},
            {22'b0, exp_q.pop_front()});
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, output logic [1:0] sel);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    #1 sel = ctl_sel_o;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d, output logic [1:0] sel);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o; sel = ctl_sel_o;
    @(posedge clk_i); #1;
    reg_rd_i = 1'b0;
  endtask

  // driver: write a control word and push the pulse it must produce
  task automatic csr_cmd(int c, logic [31:0] d, string req);
    logic [1:0] s;
    logic [9:0] e;
    e = '0;
    e[c]      = d[0];
    e[4 + c]  = d[1];
    e[8 + c/2] = d[7];
    if (e != '0) begin exp_q.push_back(e); tag_q.push_back(req); end
    bus_wr(12'h01C + 12'(c * 16), d, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  s;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 outputs", {16'b0, sync_irq_o, rx_fifo_clr_o, tx_fifo_clr_o, ctl_rst_o, ctl_lock_o},
        32'h0);
    chk("R11 err", {30'b0, ctl_err_o}, 32'h0);
    bus_rd(12'h050, rd, s); chk("R11 sync byte", rd, 32'h0);

    // R1 status patterns per channel
    rx_flags_ni = 16'b1010_0110_0000_1110;
    tx_flags_ni = 16'b0101_1001_1111_0111;
    for (int c = 0; c < N_CH; c++) begin
      bus_rd(12'h01C + 12'(c * 16), rd, s);
      chk($sformatf("R1 status ch%0d", c), rd,
          {16'b0, rx_flags_ni[c*4 +: 4], tx_flags_ni[c*4 +: 4], 8'b0});
    end

    // R2 reserved bits: no pulse expected, readback only status
    csr_cmd(1, 32'hFFFF_FF7C, "R2 reserved write");
    bus_rd(12'h02C, rd, s);
    chk("R2 csr readback", rd, {16'b0, rx_flags_ni[7:4], tx_flags_ni[7:4], 8'b0});
    chk("R2 no lock", {30'b0, ctl_lock_o}, 32'h0);

    // R8 sync byte store
    bus_wr(12'h054, 32'hFFFF_FFFF, s);
    bus_rd(12'h054, rd, s); chk("R8/R2 sync ch1 all ones", rd, 32'h0000_00FF);
    bus_wr(12'h054, 32'hABCD_EF5A, s);
    bus_rd(12'h054, rd, s); chk("R8 sync ch1", rd, 32'h0000_005A);

    // R3/R4 single pulses
    csr_cmd(2, 32'h1, "R3 tx clear ch2");
    csr_cmd(3, 32'h2, "R4 rx clear ch3");
    // R5 combined command from ch1 resets pair 0
    csr_cmd(1, 32'h83, "R5 combined ch1");
    @(negedge clk_i);
    chk("R6 pair0 locked", {30'b0, ctl_lock_o}, 32'h1);
    csr_cmd(2, 32'h80, "R5 ctl reset from ch2");
    @(negedge clk_i);
    chk("R5 both pairs locked", {30'b0, ctl_lock_o}, 32'h3);

    // R6/R7 guard on pair 0
    bus_rd(12'h104, rd, s); chk("R6 locked read blocked", {30'b0, s}, 32'h0);
    @(negedge clk_i); chk("R7 err set", {30'b0, ctl_err_o}, 32'h1);
    bus_wr(12'h100, 32'h5, s); chk("R6 nonzero base write blocked", {30'b0, s}, 32'h0);
    bus_wr(12'h120, 32'h0, s); chk("R6 zero write off base blocked", {30'b0, s}, 32'h0);
    bus_wr(12'h100, 32'h0, s); chk("R6 init write forwarded", {30'b0, s}, 32'h1);
    @(negedge clk_i); chk("R6 pair0 unlocked", {30'b0, ctl_lock_o}, 32'h2);
    bus_rd(12'h120, rd, s); chk("R6 open window forwards", {30'b0, s}, 32'h1);
    chk("R7 err sticky", {30'b0, ctl_err_o}, 32'h1);
    csr_cmd(0, 32'h80, "R5 ctl reset from ch0");
    @(negedge clk_i); chk("R7 err cleared by reset", {30'b0, ctl_err_o}, 32'h0);
    bus_wr(12'h100, 32'h0, s); chk("R6 pair0 init", {30'b0, s}, 32'h1);
    bus_wr(12'h300, 32'h0, s); chk("R6 pair1 init", {30'b0, s}, 32'h2);
    @(negedge clk_i);
    chk("R6 all unlocked", {30'b0, ctl_lock_o}, 32'h0);
    chk("R7 no err", {30'b0, ctl_err_o}, 32'h0);

    // R9 sync match
    bus_wr(12'h050, 32'h7E, s);
    bus_wr(12'h058, 32'h33, s);
    sync_irq_en_i = 4'b0011;
    @(negedge clk_i);
    rxf_wr_i = 4'b0111;
    rxf_wdata_i = {8'h00, 8'h33, 8'h7F, 8'h7E};
    @(negedge clk_i);
    rxf_wr_i = '0;
    chk("R9 match ch0 only (ch1 mismatch, ch2 disabled)", {28'b0, sync_irq_o}, 32'h1);
    repeat (2) @(negedge clk_i);
    chk("R10 irq held", {28'b0, sync_irq_o}, 32'h1);
    // R10 set wins over clear
    sync_irq_clr_i = 4'b0001; rxf_wr_i = 4'b0001;
    @(negedge clk_i);
    sync_irq_clr_i = '0; rxf_wr_i = '0;
    chk("R10 set beats clear", {28'b0, sync_irq_o}, 32'h1);
    sync_irq_clr_i = 4'b0001;
    @(negedge clk_i);
    sync_irq_clr_i = '0;
    chk("R10 cleared", {28'b0, sync_irq_o}, 32'h0);

    repeat (3) @(negedge clk_i);
    chk("R3/R4/R5 all expected pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule